// File: doc/BRIEF.md
# Hashed Frame-Indexed Translation Lookup

This block turns a (process identifier, virtual page number) pair into a physical frame number. It uses one global table with one entry for each physical frame, and the position of an entry in that table is its frame number. Each entry stores the page number and process identifier that currently own the frame, a set of access-permission bits, a link to the next entry and a valid bit.

A lookup starts by folding the requested pair into a bucket index. A separate bucket-head array maps that index to the first table entry of a collision chain. The block then follows the chain and reads one entry per clock. At each entry it compares both the stored process identifier and the stored page number with the request. A match returns the entry's index as the frame and checks the entry's permissions against the requested access. If the chain runs out, or the step limit is reached, the result is a miss.

Both arrays sit in internal synchronous memories. Software or a loader fills them through two plain write ports. Requests enter on a valid/ready channel: `req_ready` is high only while the block is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. Results leave on a valid/ready channel: `rsp_valid` and the result fields stay constant until `rsp_ready` is seen on a clock edge. Only after that edge does the block return to idle.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The bucket index is the XOR of the successive 8-bit slices of the 36-bit key {pid, vpn}, with pid in the upper bits and the top slice zero-extended. The lookup starts at the bucket-head entry for that index.
- R3: A hit needs the entry's valid bit set and both the stored pid and the stored vpn equal to the request. The returned `rsp_frame` is the index of the matching entry, with `rsp_hit`=1.
- R4: A non-matching entry passes the walk to its next field. A next field or bucket head that is not below the frame count ends the chain; the all-ones value is the reserved end marker. An ended chain gives `rsp_hit`=0 and `rsp_fault`=0.
- R5: Counting the accepting edge as edge 0, an empty bucket produces `rsp_valid` after edge 1. A lookup that ends at chain position k (0 = head) produces `rsp_valid` after edge k+2.
- R6: The permission bits are [0] read, [1] write, [2] execute. The access codes are 0 read, 1 write, 2 execute; code 3 always faults. On a hit, `rsp_fault` is 1 exactly when the bit required by the access is clear. `rsp_fault` is never 1 without `rsp_hit`.
- R7: After STEP_CAP chain entries have been examined without a match, the lookup ends as a miss, so a looped chain still completes after edge STEP_CAP+1.
- R8: `req_ready` stays 0 from the accepting edge until the edge that consumes the response. A `req_valid` during that time is ignored and gives no response.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_frame` hold their values.
- R10: An entry whose valid bit is 0 never matches, even if its fields equal the request, and the walk continues through its next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_pid | input | PID_W | Requesting process identifier |
| req_vpn | input | VPN_W | Requested virtual page number |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Matching entry found |
| rsp_fault | output | 1 | Hit with insufficient permission |
| rsp_frame | output | log2(FRAMES) | Frame number of the match |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | log2(FRAMES) | Frame index written |
| tbl_valid | input | 1 | Valid bit of written entry |
| tbl_pid | input | PID_W | Owner pid of written entry |
| tbl_vpn | input | VPN_W | Page number of written entry |
| tbl_perm | input | 3 | Permission bits of written entry |
| tbl_next | input | log2(FRAMES)+1 | Chain link of written entry |
| bkt_we | input | 1 | Write one bucket head |
| bkt_idx | input | log2(BUCKETS) | Bucket written |
| bkt_head | input | log2(FRAMES)+1 | First entry of bucket chain |

## Verification
The bench builds the block with 256 frames, 256 buckets, a 16-bit pid and a 20-bit page number, but lowers STEP_CAP to 8. With a cap of 8, a two-entry looped chain reaches the forced miss within a few cycles, and the bench can check its exact latency. The 9-bit link field also leaves values 256 to 510 free, so the bench can use them to show that any out-of-range link ends a chain, not only the all-ones marker.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_WALK,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int KEY_W  = 36,
  parameter int HASH_W = 8
) (
  input  logic [KEY_W-1:0]  key,
  output logic [HASH_W-1:0] bucket
);
  localparam int SLICES = (KEY_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W  = SLICES * HASH_W;

  logic [PAD_W-1:0] padded;
  logic [HASH_W-1:0] partial [SLICES+1];

  assign padded     = PAD_W'(key);
  assign partial[0] = '0;

  for (genvar s = 0; s < SLICES; s++) begin : g_fold
    assign partial[s+1] = partial[s] ^ padded[s*HASH_W +: HASH_W];
  end

  assign bucket = partial[SLICES];
endmodule

// File: rtl/ipt_sync_ram.sv
module ipt_sync_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ipt_perm_check.sv
module ipt_perm_check
  import ipt_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  acc_e              acc,
  output logic              allowed
);
  always_comb begin
    unique case (acc)
      ACC_READ:  allowed = perm[PERM_RD];
      ACC_WRITE: allowed = perm[PERM_WR];
      ACC_EXEC:  allowed = perm[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
#(
  parameter int FRAMES   = 256,
  parameter int BUCKETS  = 256,
  parameter int PID_W    = 16,
  parameter int VPN_W    = 20,
  parameter int STEP_CAP = 256,
  localparam int FRM_W   = $clog2(FRAMES),
  localparam int NXT_W   = FRM_W + 1,
  localparam int HASH_W  = $clog2(BUCKETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [FRM_W-1:0]  rsp_frame,
  input  logic              tbl_we,
  input  logic [FRM_W-1:0]  tbl_idx,
  input  logic              tbl_valid,
  input  logic [PID_W-1:0]  tbl_pid,
  input  logic [VPN_W-1:0]  tbl_vpn,
  input  logic [2:0]        tbl_perm,
  input  logic [NXT_W-1:0]  tbl_next,
  input  logic              bkt_we,
  input  logic [HASH_W-1:0] bkt_idx,
  input  logic [NXT_W-1:0]  bkt_head
);
  localparam int KEY_W  = PID_W + VPN_W;
  localparam int ENT_W  = 1 + PID_W + VPN_W + PERM_W + NXT_W;
  localparam int STEP_W = (STEP_CAP > 1) ? $clog2(STEP_CAP) : 1;
  localparam logic [NXT_W-1:0]  LIMIT  = NXT_W'(FRAMES);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(STEP_CAP - 1);

  walk_state_e state;
  logic [PID_W-1:0]  key_pid;
  logic [VPN_W-1:0]  key_vpn;
  acc_e              key_acc;
  logic [FRM_W-1:0]  cur;
  logic [STEP_W-1:0] steps;
  logic              hit_q, fault_q;
  logic [FRM_W-1:0]  frame_q;

  logic              accept;
  logic [HASH_W-1:0] req_bucket;
  logic [NXT_W-1:0]  head;
  logic [ENT_W-1:0]  ent;
  logic              e_valid;
  logic [PID_W-1:0]  e_pid;
  logic [VPN_W-1:0]  e_vpn;
  logic [PERM_W-1:0] e_perm;
  logic [NXT_W-1:0]  e_next;
  logic              head_ok, next_ok, match, at_cap, allowed;
  logic              tbl_re;
  logic [FRM_W-1:0]  tbl_raddr;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_hit   = hit_q;
  assign rsp_fault = fault_q;
  assign rsp_frame = frame_q;
  assign accept    = req_valid && req_ready;

  ipt_hash #(.KEY_W(KEY_W), .HASH_W(HASH_W)) u_hash (
    .key    ({req_pid, req_vpn}),
    .bucket (req_bucket)
  );

  ipt_sync_ram #(.WIDTH(NXT_W), .DEPTH(BUCKETS)) u_heads (
    .clk   (clk),
    .we    (bkt_we),
    .waddr (bkt_idx),
    .wdata (bkt_head),
    .re    (accept),
    .raddr (req_bucket),
    .rdata (head)
  );

  ipt_sync_ram #(.WIDTH(ENT_W), .DEPTH(FRAMES)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_idx),
    .wdata ({tbl_valid, tbl_pid, tbl_vpn, tbl_perm, tbl_next}),
    .re    (tbl_re),
    .raddr (tbl_raddr),
    .rdata (ent)
  );

  assign {e_valid, e_pid, e_vpn, e_perm, e_next} = ent;

  ipt_perm_check u_perm (
    .perm    (e_perm),
    .acc     (key_acc),
    .allowed (allowed)
  );

  // Chain links at or above the frame count (including all-ones) end the walk
  assign head_ok = (head < LIMIT);
  assign next_ok = (e_next < LIMIT);
  assign match   = e_valid && (e_pid == key_pid) && (e_vpn == key_vpn);
  assign at_cap  = (steps == LAST_S);

  always_comb begin
    tbl_re    = 1'b0;
    tbl_raddr = e_next[FRM_W-1:0];
    if (state == ST_HEAD) begin
      tbl_re    = head_ok;
      tbl_raddr = head[FRM_W-1:0];
    end else if (state == ST_WALK) begin
      tbl_re    = !match && next_ok && !at_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      key_pid <= '0;
      key_vpn <= '0;
      key_acc <= ACC_READ;
      cur     <= '0;
      steps   <= '0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      frame_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            key_pid <= req_pid;
            key_vpn <= req_vpn;
            key_acc <= acc_e'(req_acc);
            state   <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (head_ok) begin
            cur   <= head[FRM_W-1:0];
            steps <= '0;
            state <= ST_WALK;
          end else begin
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            frame_q <= '0;
            state   <= ST_DONE;
          end
        end
        ST_WALK: begin
          if (match) begin
            hit_q   <= 1'b1;
            fault_q <= !allowed;
            frame_q <= cur;
            state   <= ST_DONE;
          end else if (!next_ok || at_cap) begin
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            frame_q <= '0;
            state   <= ST_DONE;
          end else begin
            cur   <= e_next[FRM_W-1:0];
            steps <= steps + 1'b1;
          end
        end
        ST_DONE: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int FRAMES   = 256,
  parameter int STEP_CAP = 256,
  localparam int FRM_W   = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [FRM_W-1:0] rsp_frame
);
  int unsigned wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wait_cnt <= 0;
    else if (req_valid && req_ready)    wait_cnt <= 0;
    else if (!req_ready && !rsp_valid)  wait_cnt <= wait_cnt + 1;
  end

  // R8: no new request is taken while a lookup is outstanding
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R8: consuming the response returns the block to idle
  p_idle_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !rsp_valid);

  // R9: a stalled response holds every field
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
                                && $stable(rsp_fault) && $stable(rsp_frame));

  // R6: a fault is reported only together with a hit
  p_fault_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_hit);

  // R7: every lookup finishes within the step limit
  p_step_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= STEP_CAP + 1);
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES), .STEP_CAP(STEP_CAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_frame (rsp_frame)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int CAP = 8;
  localparam logic [8:0] ENDM = 9'h1FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 0;
  logic [15:0] req_pid = '0;
  logic [19:0] req_vpn = '0;
  logic [1:0]  req_acc = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [7:0] rsp_frame;
  logic tbl_we = 0, tbl_valid = 0;
  logic [7:0] tbl_idx = '0;
  logic [15:0] tbl_pid = '0;
  logic [19:0] tbl_vpn = '0;
  logic [2:0] tbl_perm = '0;
  logic [8:0] tbl_next = '0;
  logic bkt_we = 0;
  logic [7:0] bkt_idx = '0;
  logic [8:0] bkt_head = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ipt_lookup #(.STEP_CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_vpn(req_vpn), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_frame(rsp_frame),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_pid(tbl_pid), .tbl_vpn(tbl_vpn), .tbl_perm(tbl_perm), .tbl_next(tbl_next),
    .bkt_we(bkt_we), .bkt_idx(bkt_idx), .bkt_head(bkt_head)
  );

  // R2: bit i of the key lands in bucket bit i mod 8
  function automatic logic [7:0] bucket_of(input logic [15:0] pid, input logic [19:0] vpn);
    logic [35:0] k;
    logic [7:0]  h;
    k = {pid, vpn};
    h = '0;
    for (int i = 0; i < 36; i++) h[i % 8] ^= k[i];
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_entry(input int idx, input bit v, input logic [15:0] pid,
                          input logic [19:0] vpn, input logic [2:0] perm, input logic [8:0] nxt);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 8'(idx); tbl_valid = v; tbl_pid = pid;
    tbl_vpn = vpn; tbl_perm = perm; tbl_next = nxt;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_bucket(input logic [7:0] idx, input logic [8:0] head);
    @(negedge clk);
    bkt_we = 1; bkt_idx = idx; bkt_head = head;
    @(negedge clk);
    bkt_we = 0;
  endtask

  task automatic lookup(input logic [15:0] pid, input logic [19:0] vpn, input logic [1:0] acc,
                        output logic hit, output logic fault, output logic [7:0] frame,
                        output int lat);
    @(negedge clk);
    req_pid = pid; req_vpn = vpn; req_acc = acc; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 2000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    hit = rsp_hit; fault = rsp_fault; frame = rsp_frame;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_empty;
    logic h, f; logic [7:0] fr; int lat;
    lookup(16'h0042, 20'h12345, 2'd0, h, f, fr, lat);
    chk(h == 1'b0, "R4", "empty bucket hit", h, 0);
    chk(lat == 1, "R5", "empty bucket latency", lat, 1);
  endtask

  task automatic t_chain;
    logic h, f; logic [7:0] fr; int lat;
    logic [15:0] kp = 16'h0007;
    logic [19:0] kv = 20'h0A0B0;
    wr_entry(10, 1, kp ^ 16'h1010, kv, 3'b111, 9'd20);
    wr_entry(20, 0, kp, kv, 3'b111, 9'd30);
    wr_entry(30, 1, kp, kv, 3'b111, ENDM);
    wr_bucket(bucket_of(kp, kv), 9'd10);
    // R3 R10: third entry matches, invalid twin at position 1 is skipped
    lookup(kp, kv, 2'd0, h, f, fr, lat);
    chk(h == 1'b1, "R10", "hit past invalid twin", h, 1);
    chk(fr == 8'd30, "R3", "frame at chain end", fr, 30);
    chk(lat == 4, "R5", "latency position 2", lat, 4);
    // R3: same vpn, other pid in the same bucket matches the head only
    lookup(kp ^ 16'h1010, kv, 2'd0, h, f, fr, lat);
    chk(h == 1'b1 && fr == 8'd10, "R3", "pid-distinct head frame", fr, 10);
    chk(lat == 2, "R5", "latency position 0", lat, 2);
    // R4: colliding key absent from chain
    lookup(kp, kv ^ 20'h00101, 2'd0, h, f, fr, lat);
    chk(h == 1'b0 && f == 1'b0, "R4", "colliding absent key hit", h, 0);
    chk(lat == 4, "R4", "miss after end marker latency", lat, 4);
  endtask

  task automatic t_range;
    logic h, f; logic [7:0] fr; int lat;
    wr_entry(50, 1, 16'h0100, 20'h33334, 3'b111, 9'd300);
    wr_entry(51, 1, 16'h0100, 20'h33333, 3'b111, ENDM);
    wr_bucket(bucket_of(16'h0100, 20'h33333), 9'd50);
    lookup(16'h0100, 20'h33333, 2'd0, h, f, fr, lat);
    chk(h == 1'b0, "R4", "out-of-range link ends chain", h, 0);
    chk(lat == 2, "R4", "out-of-range link latency", lat, 2);
  endtask

  task automatic t_perm;
    logic h, f; logic [7:0] fr; int lat;
    logic [15:0] p = 16'h0ABC;
    logic [19:0] v = 20'h00777;
    wr_entry(60, 1, p, v, 3'b001, ENDM);
    wr_bucket(bucket_of(p, v), 9'd60);
    lookup(p, v, 2'd0, h, f, fr, lat);
    chk(h && !f && fr == 8'd60, "R6", "read on read-only fault", f, 0);
    lookup(p, v, 2'd1, h, f, fr, lat);
    chk(h && f, "R6", "write on read-only fault", f, 1);
    lookup(p, v, 2'd2, h, f, fr, lat);
    chk(h && f, "R6", "exec on read-only fault", f, 1);
    lookup(p, v, 2'd3, h, f, fr, lat);
    chk(h && f, "R6", "reserved access fault", f, 1);
    wr_entry(60, 1, p, v, 3'b110, ENDM);
    lookup(p, v, 2'd0, h, f, fr, lat);
    chk(h && f, "R6", "read on write-exec fault", f, 1);
    lookup(p, v, 2'd1, h, f, fr, lat);
    chk(h && !f, "R6", "write on write-exec fault", f, 0);
    lookup(p, v, 2'd2, h, f, fr, lat);
    chk(h && !f, "R6", "exec on write-exec fault", f, 0);
  endtask

  task automatic t_loop;
    logic h, f; logic [7:0] fr; int lat;
    wr_entry(40, 1, 16'h2222, 20'h44445, 3'b111, 9'd41);
    wr_entry(41, 1, 16'h2222, 20'h44446, 3'b111, 9'd40);
    wr_bucket(bucket_of(16'h2222, 20'h44444), 9'd40);
    lookup(16'h2222, 20'h44444, 2'd0, h, f, fr, lat);
    chk(h == 1'b0, "R7", "looped chain hit", h, 0);
    chk(lat == CAP + 1, "R7", "looped chain latency", lat, CAP + 1);
  endtask

  task automatic t_hold;
    int lat;
    logic [7:0] fr0;
    @(negedge clk);
    req_pid = 16'h0ABC; req_vpn = 20'h00777; req_acc = 2'd1; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    // R8: a second request while busy
    req_pid = 16'h0007; req_vpn = 20'h0A0B0; req_acc = 2'd0;
    chk(req_ready == 1'b0, "R8", "ready while busy", req_ready, 0);
    lat = 0;
    while (!rsp_valid && lat < 2000) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    fr0 = rsp_frame;
    chk(fr0 == 8'd60, "R9", "stalled frame", fr0, 60);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == 1'b1, "R9", "rsp_valid held", rsp_valid, 1);
      chk(rsp_frame == fr0 && rsp_hit && !rsp_fault, "R9", "fields held", rsp_frame, fr0);
      chk(req_ready == 1'b0, "R8", "ready during stall", req_ready, 0);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == 1'b0, "R8", "ignored request response", rsp_valid, 0);
    end
    chk(req_ready == 1'b1, "R8", "idle after consume", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    for (int i = 0; i < 256; i++) begin
      wr_bucket(8'(i), ENDM);
      wr_entry(i, 0, '0, '0, '0, ENDM);
    end
    t_empty();
    t_chain();
    t_range();
    t_perm();
    t_loop();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule